// File: doc/BRIEF.md
# Partitioned Load Buffer Allocator

This block manages a pool of load-buffer entries for an out-of-order core. The allocate stage reserves one entry per cycle in program order, tagging it with the requesting thread and a sequence age. Later, the dispatch port fills the reserved entry when the load executes. Each entry records whether it is valid, its thread, its age, its memory-type class, whether it was filled speculatively, and whether its data is ready. An entry is released when its load retires, or when a mispredicted branch squashes the younger loads of that thread.

A mode input selects shared or two-thread operation. In two-thread mode the pool is cut into two fixed halves. Thread 0 owns the lower half and thread 1 owns the upper half. Neither thread ever borrows entries from the other. At dispatch the block decides whether a load beyond an unresolved branch may go ahead. It holds speculative loads to uncached memory, and it holds speculative loads that would fault, until the branch has resolved.

Top module: `ldbuf_pool`

## Requirements
- R1: After reset no entry is valid. An idle cycle drives alloc_gnt_o, disp_issue_o, disp_hold_o and commit_o low. In split mode the first grant for thread 1 is index 24 (N_ENT/2).
- R2: An allocation request is granted in the same cycle whenever the permitted range has a free entry. The grant names the lowest free index in that range, and at most one entry is granted per cycle.
- R3: With split_i=1, thread 0 receives only indices 0..23 and thread 1 only indices 24..47. A thread whose half is full gets alloc_gnt_o=0, even when the other half has free entries.
- R4: With split_i=0, requests from either thread are served from the whole pool of 48 entries. The request is refused only when all 48 are taken.
- R5: A dispatch to a valid entry that has not yet been filled raises either disp_issue_o or disp_hold_o, and never both. After an issue, the entry is data-ready and records the flag disp_spec_i. A dispatch to an invalid entry raises neither.
- R6: Memory-type codes are UC=0, WC=1, WT=4, WP=5 and WB=6; any other code is handled like UC. A dispatch with disp_spec_i=1 and memory type UC is held (disp_hold_o=1) and the entry stays unfilled. WC, WT, WP and WB issue while speculative. A non-speculative UC load issues.
- R7: A dispatch with disp_spec_i=1 and disp_fault_i=1 is held whatever its memory type. With disp_spec_i=0, a faulting load issues.
- R8: A retire request raises commit_o in the same cycle only if the entry is valid, data-ready and not speculative. A committed entry becomes free at the next edge.
- R9: A resolve with res_wrong_i=1 invalidates, in one cycle, every entry of res_tid_i whose age is younger than res_age_i. Younger means that (entry_age - res_age_i) mod 64 lies in 1..31. Squashed entries never commit, and they are free for the next allocation. Entries that are older or equal in age, and entries of the other thread, are left unchanged.
- R10: A retire of a speculative entry is refused (commit_o=0) and the entry is kept. A resolve with res_wrong_i=0 clears the speculative flag of the younger entries of that thread, after which they can commit.
- R11: When one cycle both releases an entry and requests allocation, the release is applied first. A full partition can therefore be granted the entry that is retiring in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| split_i | input | 1 | 1: pool split between two threads; 0: shared |
| alloc_req_i | input | 1 | Allocation request |
| alloc_tid_i | input | 1 | Thread of the allocating load |
| alloc_age_i | input | 6 | Sequence age of the allocating load |
| alloc_gnt_o | output | 1 | Allocation granted this cycle |
| alloc_idx_o | output | 6 | Granted entry index |
| disp_req_i | input | 1 | Dispatch of a load into its entry |
| disp_idx_i | input | 6 | Entry being dispatched |
| disp_mtype_i | input | 3 | Memory-type class of the load |
| disp_spec_i | input | 1 | Load lies beyond an unresolved branch |
| disp_fault_i | input | 1 | Load would cause a page fault |
| disp_issue_o | output | 1 | Load executes and fills the entry |
| disp_hold_o | output | 1 | Load must wait for branch resolution |
| res_valid_i | input | 1 | Branch resolution valid |
| res_wrong_i | input | 1 | Branch was mispredicted |
| res_tid_i | input | 1 | Thread of the resolved branch |
| res_age_i | input | 6 | Age tag of the resolved branch |
| ret_req_i | input | 1 | Retire request |
| ret_idx_i | input | 6 | Entry to retire |
| commit_o | output | 1 | Retire accepted, data written back |

## Verification
The assertions take for granted that split_i changes only while the pool is empty or held in reset. They also assume that dispatch and retire indices point into the pool, and that every live entry of a thread lies within 31 ages of any branch tag presented for it. The stimulus keeps to these limits. It changes the mode only across a reset, uses ages that rise by small steps well inside the 64-value window, and dispatches or retires only indices it has been granted, apart from deliberate probes of squashed or unfilled entries. No branch resolution is driven in the same cycle as an allocation of that thread, so a grant never has to be weighed against a squash.

// File: rtl/ldbuf_pkg.sv
package ldbuf_pkg;

  typedef enum logic [2:0] {
    MT_UC = 3'd0,
    MT_WC = 3'd1,
    MT_WT = 3'd4,
    MT_WP = 3'd5,
    MT_WB = 3'd6
  } mtype_e;

  // only these classes may be read ahead of an unresolved branch
  function automatic logic spec_allowed(logic [2:0] mt);
    case (mt)
      MT_WC, MT_WT, MT_WP, MT_WB: spec_allowed = 1'b1;
      default:                    spec_allowed = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ldbuf_pick.sv
module ldbuf_pick #(
  parameter int N_ENT = 48,
  parameter int IDX_W = $clog2(N_ENT)
) (
  input  logic [N_ENT-1:0] mask_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (mask_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/ldbuf_gate.sv
module ldbuf_gate (
  input  logic       spec_i,
  input  logic       fault_i,
  input  logic [2:0] mtype_i,
  output logic       hold_o
);

  always_comb begin
    hold_o = 1'b0;
    if (spec_i) begin
      if (fault_i) hold_o = 1'b1;
      else if (!ldbuf_pkg::spec_allowed(mtype_i)) hold_o = 1'b1;
    end
  end

endmodule

// File: rtl/ldbuf_squash.sv
module ldbuf_squash #(
  parameter int N_ENT = 48,
  parameter int AGE_W = 6
) (
  input  logic                        res_valid_i,
  input  logic                        res_wrong_i,
  input  logic                        res_tid_i,
  input  logic [AGE_W-1:0]            res_age_i,
  input  logic [N_ENT-1:0]            ent_valid_i,
  input  logic [N_ENT-1:0]            ent_tid_i,
  input  logic [N_ENT-1:0][AGE_W-1:0] ent_age_i,
  output logic [N_ENT-1:0]            kill_o,
  output logic [N_ENT-1:0]            unspec_o
);

  for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
    logic [AGE_W-1:0] diff;
    logic             younger;
    logic             hit;
    // modular distance: younger if entry is ahead of the tag by less than half the range
    assign diff    = ent_age_i[i] - res_age_i;
    assign younger = (diff != '0) && !diff[AGE_W-1];
    assign hit     = res_valid_i && ent_valid_i[i] && (ent_tid_i[i] == res_tid_i) && younger;
    assign kill_o[i]   = hit && res_wrong_i;
    assign unspec_o[i] = hit && !res_wrong_i;
  end

endmodule

// File: rtl/ldbuf_entries.sv
module ldbuf_entries #(
  parameter int N_ENT = 48,
  parameter int AGE_W = 6,
  parameter int IDX_W = $clog2(N_ENT)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        alloc_we_i,
  input  logic [IDX_W-1:0]            alloc_idx_i,
  input  logic                        alloc_tid_i,
  input  logic [AGE_W-1:0]            alloc_age_i,
  input  logic                        disp_we_i,
  input  logic [IDX_W-1:0]            disp_idx_i,
  input  logic                        disp_spec_i,
  input  logic [2:0]                  disp_mtype_i,
  input  logic [N_ENT-1:0]            rel_i,
  input  logic [N_ENT-1:0]            unspec_i,
  output logic [N_ENT-1:0]            valid_o,
  output logic [N_ENT-1:0]            tid_o,
  output logic [N_ENT-1:0][AGE_W-1:0] age_o,
  output logic [N_ENT-1:0]            spec_o,
  output logic [N_ENT-1:0]            ready_o,
  output logic [N_ENT-1:0][2:0]       mtype_o
);

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    logic             v_q, t_q, s_q, r_q;
    logic [AGE_W-1:0] a_q;
    logic [2:0]       m_q;
    logic             a_hit, d_hit;

    assign a_hit = alloc_we_i && (alloc_idx_i == IDX_W'(i));
    assign d_hit = disp_we_i && (disp_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        t_q <= 1'b0;
        s_q <= 1'b0;
        r_q <= 1'b0;
        a_q <= '0;
        m_q <= 3'd0;
      end else if (a_hit) begin
        // allocation wins over a release of the same slot (release already applied)
        v_q <= 1'b1;
        t_q <= alloc_tid_i;
        a_q <= alloc_age_i;
        s_q <= 1'b0;
        r_q <= 1'b0;
        m_q <= 3'd0;
      end else begin
        if (rel_i[i]) v_q <= 1'b0;
        if (d_hit) begin
          r_q <= 1'b1;
          s_q <= disp_spec_i;
          m_q <= disp_mtype_i;
        end else if (unspec_i[i]) begin
          s_q <= 1'b0;
        end
      end
    end

    assign valid_o[i] = v_q;
    assign tid_o[i]   = t_q;
    assign age_o[i]   = a_q;
    assign spec_o[i]  = s_q;
    assign ready_o[i] = r_q;
    assign mtype_o[i] = m_q;
  end

endmodule

// File: rtl/ldbuf_pool.sv
module ldbuf_pool #(
  parameter int N_ENT = 48,
  parameter int AGE_W = 6,
  parameter int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             split_i,
  input  logic             alloc_req_i,
  input  logic             alloc_tid_i,
  input  logic [AGE_W-1:0] alloc_age_i,
  output logic             alloc_gnt_o,
  output logic [IDX_W-1:0] alloc_idx_o,
  input  logic             disp_req_i,
  input  logic [IDX_W-1:0] disp_idx_i,
  input  logic [2:0]       disp_mtype_i,
  input  logic             disp_spec_i,
  input  logic             disp_fault_i,
  output logic             disp_issue_o,
  output logic             disp_hold_o,
  input  logic             res_valid_i,
  input  logic             res_wrong_i,
  input  logic             res_tid_i,
  input  logic [AGE_W-1:0] res_age_i,
  input  logic             ret_req_i,
  input  logic [IDX_W-1:0] ret_idx_i,
  output logic             commit_o
);

  localparam int HALF = N_ENT / 2;

  logic [N_ENT-1:0]            ent_valid, ent_tid, ent_spec, ent_ready;
  logic [N_ENT-1:0][AGE_W-1:0] ent_age;
  logic [N_ENT-1:0][2:0]       ent_mtype;
  logic [N_ENT-1:0]            kill, unspec, rel, permit, free_m, ret_oh;
  logic                        found, hold, disp_hit;
  logic                        disp_in, ret_in;

  ldbuf_squash #(.N_ENT(N_ENT), .AGE_W(AGE_W)) u_squash (
    .res_valid_i (res_valid_i),
    .res_wrong_i (res_wrong_i),
    .res_tid_i   (res_tid_i),
    .res_age_i   (res_age_i),
    .ent_valid_i (ent_valid),
    .ent_tid_i   (ent_tid),
    .ent_age_i   (ent_age),
    .kill_o      (kill),
    .unspec_o    (unspec)
  );

  // retire path
  assign ret_in   = ret_idx_i < IDX_W'(N_ENT);
  assign commit_o = ret_req_i && ret_in && ent_valid[ret_idx_i] && ent_ready[ret_idx_i]
                    && !ent_spec[ret_idx_i] && !kill[ret_idx_i];
  assign ret_oh   = commit_o ? (N_ENT'(1) << ret_idx_i) : '0;
  assign rel      = kill | ret_oh;

  // allocation: releases of this cycle count as free
  always_comb begin
    for (int i = 0; i < N_ENT; i++) begin
      if (!split_i)         permit[i] = 1'b1;
      else if (alloc_tid_i) permit[i] = (i >= HALF);
      else                  permit[i] = (i < HALF);
    end
  end

  assign free_m = (~ent_valid | rel) & permit;

  ldbuf_pick #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_pick (
    .mask_i  (free_m),
    .found_o (found),
    .idx_o   (alloc_idx_o)
  );

  assign alloc_gnt_o = alloc_req_i && found;

  // dispatch path
  ldbuf_gate u_gate (
    .spec_i  (disp_spec_i),
    .fault_i (disp_fault_i),
    .mtype_i (disp_mtype_i),
    .hold_o  (hold)
  );

  assign disp_in      = disp_idx_i < IDX_W'(N_ENT);
  assign disp_hit     = disp_req_i && disp_in && ent_valid[disp_idx_i]
                        && !ent_ready[disp_idx_i] && !kill[disp_idx_i];
  assign disp_issue_o = disp_hit && !hold;
  assign disp_hold_o  = disp_hit && hold;

  ldbuf_entries #(.N_ENT(N_ENT), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_ent (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_we_i   (alloc_gnt_o),
    .alloc_idx_i  (alloc_idx_o),
    .alloc_tid_i  (alloc_tid_i),
    .alloc_age_i  (alloc_age_i),
    .disp_we_i    (disp_issue_o),
    .disp_idx_i   (disp_idx_i),
    .disp_spec_i  (disp_spec_i),
    .disp_mtype_i (disp_mtype_i),
    .rel_i        (rel),
    .unspec_i     (unspec),
    .valid_o      (ent_valid),
    .tid_o        (ent_tid),
    .age_o        (ent_age),
    .spec_o       (ent_spec),
    .ready_o      (ent_ready),
    .mtype_o      (ent_mtype)
  );

endmodule

// File: rtl/ldbuf_pool_chk.sv
module ldbuf_pool_chk #(
  parameter int N_ENT = 48,
  parameter int AGE_W = 6,
  parameter int IDX_W = $clog2(N_ENT)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  split_i,
  input logic                  alloc_tid_i,
  input logic                  alloc_gnt_o,
  input logic [IDX_W-1:0]      alloc_idx_o,
  input logic                  disp_req_i,
  input logic [2:0]            disp_mtype_i,
  input logic                  disp_spec_i,
  input logic                  disp_fault_i,
  input logic                  disp_issue_o,
  input logic                  disp_hold_o,
  input logic                  ret_req_i,
  input logic [IDX_W-1:0]      ret_idx_i,
  input logic                  commit_o,
  input logic [N_ENT-1:0]      ent_valid,
  input logic [N_ENT-1:0]      ent_spec,
  input logic [N_ENT-1:0]      ent_ready,
  input logic [N_ENT-1:0][2:0] ent_mtype
);

  localparam logic [IDX_W-1:0] HALF_IDX = IDX_W'(N_ENT / 2);
  localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(N_ENT - 1);

  // R3
  t0_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    split_i && alloc_gnt_o && !alloc_tid_i |-> alloc_idx_o < HALF_IDX);

  // R3
  t1_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    split_i && alloc_gnt_o && alloc_tid_i |-> alloc_idx_o >= HALF_IDX && alloc_idx_o <= TOP_IDX);

  // R6
  uc_spec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_req_i && disp_spec_i && (disp_mtype_i == ldbuf_pkg::MT_UC) |-> !disp_issue_o);

  // R7
  fault_spec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_req_i && disp_spec_i && disp_fault_i |-> !disp_issue_o);

  // R5
  issue_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(disp_issue_o && disp_hold_o));

  // R8
  commit_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o && !(alloc_gnt_o && alloc_idx_o == ret_idx_i) |=> !ent_valid[$past(ret_idx_i)]);

  // R6
  stored_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_req_i && ent_valid[ret_idx_i] && ent_ready[ret_idx_i] && ent_spec[ret_idx_i]
    |-> ent_mtype[ret_idx_i] != ldbuf_pkg::MT_UC);

endmodule

bind ldbuf_pool ldbuf_pool_chk #(.N_ENT(N_ENT), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/ldbuf_pool_test.sv
module ldbuf_pool_test;

  localparam int N_ENT = 48;
  localparam int AGE_W = 6;
  localparam int IDX_W = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic split_i, alloc_req_i, alloc_tid_i, disp_req_i, disp_spec_i, disp_fault_i;
  logic res_valid_i, res_wrong_i, res_tid_i, ret_req_i;
  logic [AGE_W-1:0] alloc_age_i, res_age_i;
  logic [IDX_W-1:0] disp_idx_i, ret_idx_i;
  logic [2:0] disp_mtype_i;
  logic alloc_gnt_o, disp_issue_o, disp_hold_o, commit_o;
  logic [IDX_W-1:0] alloc_idx_o;

  always #2.5 clk_i = ~clk_i;

  ldbuf_pool uut (.*);

  typedef struct {
    string nm;
    logic  g;
    int    ix;
    logic  is;
    logic  ho;
    logic  cm;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  task automatic idle();
    alloc_req_i = 0; alloc_tid_i = 0; alloc_age_i = '0;
    disp_req_i = 0; disp_idx_i = '0; disp_mtype_i = 3'd6; disp_spec_i = 0; disp_fault_i = 0;
    res_valid_i = 0; res_wrong_i = 0; res_tid_i = 0; res_age_i = '0;
    ret_req_i = 0; ret_idx_i = '0;
  endtask

  task automatic step(string nm, logic g, int ix, logic is, logic ho, logic cm);
    exp_t e;
    e.nm = nm; e.g = g; e.ix = ix; e.is = is; e.ho = ho; e.cm = cm;
    q.push_back(e);
    @(posedge clk_i);
    @(negedge clk_i);
    idle();
  endtask

  task automatic alloc(bit t, int age);
    alloc_req_i = 1; alloc_tid_i = t; alloc_age_i = AGE_W'(age);
  endtask

  task automatic disp(int ix, logic [2:0] mt, bit sp, bit flt);
    disp_req_i = 1; disp_idx_i = IDX_W'(ix); disp_mtype_i = mt; disp_spec_i = sp; disp_fault_i = flt;
  endtask

  task automatic retire(int ix);
    ret_req_i = 1; ret_idx_i = IDX_W'(ix);
  endtask

  task automatic resolve(bit t, int age, bit wrong);
    res_valid_i = 1; res_tid_i = t; res_age_i = AGE_W'(age); res_wrong_i = wrong;
  endtask

  // monitor: compares outputs mid-cycle against the queued expectation
  always @(negedge clk_i) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (alloc_gnt_o !== e.g || (e.g && int'(alloc_idx_o) != e.ix) || disp_issue_o !== e.is
          || disp_hold_o !== e.ho || commit_o !== e.cm) begin
        n_err++;
        $display("FAIL %s: gnt/idx/issue/hold/commit act=%b/%0d/%b/%b/%b exp=%b/%0d/%b/%b/%b",
                 e.nm, alloc_gnt_o, alloc_idx_o, disp_issue_o, disp_hold_o, commit_o,
                 e.g, e.ix, e.is, e.ho, e.cm);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    idle();
    split_i = 1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1;

    // ---- split mode ----
    step("R1 idle after reset", 0, 0, 0, 0, 0);
    alloc(1, 10);          step("R1 first t1 grant", 1, 24, 0, 0, 0);
    alloc(0, 1);           step("R2 t0 lowest", 1, 0, 0, 0, 0);
    alloc(0, 2);           step("R2 t0 next", 1, 1, 0, 0, 0);
    disp(0, 3'd0, 0, 0);   step("R6 nonspec UC issues", 0, 0, 1, 0, 0);
    disp(1, 3'd0, 1, 0);   step("R6 spec UC held", 0, 0, 0, 1, 0);
    disp(1, 3'd6, 1, 0);   step("R6 spec WB issues", 0, 0, 1, 0, 0);
    retire(1);             step("R10 spec retire refused", 0, 0, 0, 0, 0);
    retire(0);             step("R8 retire ready entry", 0, 0, 0, 0, 1);
    alloc(0, 3);           step("R2 freed slot reused", 1, 0, 0, 0, 0);
    disp(0, 3'd4, 1, 1);   step("R7 spec fault held", 0, 0, 0, 1, 0);
    resolve(0, 1, 0);      step("R10 correct resolve", 0, 0, 0, 0, 0);
    retire(1);             step("R10 retire after resolve", 0, 0, 0, 0, 1);
    disp(0, 3'd1, 0, 1);   step("R7 nonspec fault issues", 0, 0, 1, 0, 0);
    retire(24);            step("R8 unfilled retire refused", 0, 0, 0, 0, 0);
    disp(2, 3'd6, 0, 0);   step("R5 invalid entry ignored", 0, 0, 0, 0, 0);
    for (int k = 1; k < 24; k++) begin
      alloc(0, k + 3);     step("R2 fill t0 half", 1, k, 0, 0, 0);
    end
    alloc(0, 30);          step("R3 t0 half full stalls", 0, 0, 0, 0, 0);
    alloc(1, 11);          step("R3 t1 still served", 1, 25, 0, 0, 0);
    alloc(0, 27); retire(0);
    step("R11 free first same cycle", 1, 0, 0, 0, 1);
    disp(5, 3'd6, 1, 0);   step("R5 spec fill idx5", 0, 0, 1, 0, 0);
    disp(20, 3'd5, 1, 0);  step("R5 spec fill idx20", 0, 0, 1, 0, 0);
    resolve(0, 10, 1);     step("R9 squash", 0, 0, 0, 0, 0);
    alloc(0, 11);          step("R9 squashed idx0 free", 1, 0, 0, 0, 0);
    alloc(0, 12);          step("R9 squashed idx8 free", 1, 8, 0, 0, 0);
    retire(20);            step("R9 squashed never commits", 0, 0, 0, 0, 0);
    disp(9, 3'd6, 0, 0);   step("R9 squashed entry gone", 0, 0, 0, 0, 0);
    disp(7, 3'd6, 0, 0);   step("R9 equal age kept", 0, 0, 1, 0, 0);
    disp(24, 3'd6, 0, 0);  step("R9 other thread kept", 0, 0, 1, 0, 0);
    retire(24);            step("R9 other thread commits", 0, 0, 0, 0, 1);
    resolve(0, 5, 0);      step("R10 clear spec idx5", 0, 0, 0, 0, 0);
    retire(5);             step("R10 older entry commits", 0, 0, 0, 0, 1);

    // ---- shared mode ----
    rst_ni = 0;
    split_i = 0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1;
    step("R1 idle shared", 0, 0, 0, 0, 0);
    for (int k = 0; k < N_ENT; k++) begin
      alloc(1, k % 32);    step("R4 t1 uses whole pool", 1, k, 0, 0, 0);
    end
    alloc(0, 5);           step("R4 pool full refuses", 0, 0, 0, 0, 0);
    disp(3, 3'd6, 0, 0);   step("R5 fill idx3", 0, 0, 1, 0, 0);
    alloc(0, 6); retire(3);
    step("R11 shared free first", 1, 3, 0, 0, 1);

    repeat (2) @(posedge clk_i);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

endmodule